// File: doc/BRIEF.md
# I2C Master Receive Byte Counter

This block keeps track of how far an I2C master read has progressed. Software programs a control word that holds an 8-bit count and an extend flag. The count is the number of bytes wanted minus one. The bit engine raises a one-cycle strobe for every byte it receives. The block increments a running count on each strobe, and software can read that count back at any time. On the final byte of a normal read, the block raises a one-cycle last-byte pulse. The bit engine uses that pulse to NACK the byte and issue a stop.

When the extend flag is set, the block never raises the last-byte pulse. The running count simply wraps from 255 back to 0. A read longer than 256 bytes therefore works as follows:
- Software first writes the extend flag with a count of 0.
- It watches the running count return to 0, which marks 256 received bytes.
- It then writes the remainder minus one with the extend flag cleared.

Every control write clears the running count.

Top module: `i2c_rx_byte_counter`

## Requirements
- R1: After an asynchronous reset, the running count is 0, the control readback is 0 and the last-byte pulse is low.
- R2: The control readback returns the last written bits [8:0]. Bit 8 is the extend flag and bits [7:0] are the count. Bits [15:9] always read 0.
- R3: A control write clears the running count on the next clock. A byte strobe in the same cycle as a write has no effect: it causes no increment and no last-byte pulse.
- R4: A byte strobe without a write increments the running count by one, modulo 256, visible on the next clock.
- R5: With extend at 0, a byte strobe while the running count equals the programmed count raises the last-byte pulse for exactly one cycle, on the next clock.
- R6: With a programmed count of 0 and extend at 0, the first byte after the write is the last byte.
- R7: With extend at 1, the last-byte pulse never rises, and 256 strobes return the running count to 0.
- R8: In a cycle with neither a strobe nor a write, the running count holds and the last-byte pulse is low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 16 | Control write data |
| cfg_rdata_o | output | 16 | Control register readback |
| byte_rx_i | input | 1 | One-cycle strobe per received byte |
| cur_cnt_o | output | 8 | Running count of received bytes |
| last_byte_o | output | 1 | One-cycle pulse: NACK this byte and stop |

## Verification
The bench targets the following corner cases:
- **Off-by-one in the minus-one encoding.** A count of 0 must end on the first byte. A count of 0x9B must end on the 156th byte. A design that compares against the count plus one would end one byte late.
- **Termination at the 255-to-0 wrap in extended mode.** A design that ignores the extend flag would stop a long read 256 bytes early.
- **Write and strobe in the same cycle.** A design that lets the strobe win would leave the count at 1 instead of 0.
- **Extend write sequence.** A 256-byte extended run followed by a non-extended reload must deliver exactly 412 bytes with a single pulse.

Random writes and strobes cover the remaining state combinations.

// File: rtl/i2c_rxc_pkg.sv
package i2c_rxc_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned REG_W = 16;

  typedef struct packed {
    logic             ext;
    logic [CNT_W-1:0] cnt;
  } rxc_ctl_t;
endpackage

// File: rtl/rxc_ctl_reg.sv
module rxc_ctl_reg
  import i2c_rxc_pkg::*;
#(
  parameter int unsigned RW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] wdata_i,
  output rxc_ctl_t      ctl_o,
  output logic [RW-1:0] rdata_o
);
  localparam int unsigned CW = $bits(rxc_ctl_t);

  rxc_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= rxc_ctl_t'(wdata_i[CW-1:0]);
  end

  assign ctl_o   = ctl_q;
  assign rdata_o = {{(RW-CW){1'b0}}, ctl_q};
endmodule

// File: rtl/rxc_byte_cnt.sv
module rxc_byte_cnt
  import i2c_rxc_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  // clear wins over increment; natural wrap gives modulo 2**W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rxc_last_det.sv
module rxc_last_det
  import i2c_rxc_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         byte_i,
  input  logic         ext_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prog_i,
  output logic         last_o
);
  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= byte_i && !ext_i && (cur_i == prog_i);
  end

  assign last_o = last_q;
endmodule

// File: rtl/i2c_rx_byte_counter.sv
module i2c_rx_byte_counter
  import i2c_rxc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  input  logic             byte_rx_i,
  output logic [CNT_W-1:0] cur_cnt_o,
  output logic             last_byte_o
);
  rxc_ctl_t   ctl;
  logic       byte_ok;

  // a write in the same cycle as a strobe discards the strobe
  assign byte_ok = byte_rx_i && !cfg_we_i;

  rxc_ctl_reg #(.RW(REG_W)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .ctl_o   (ctl),
    .rdata_o (cfg_rdata_o)
  );

  rxc_byte_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_we_i),
    .inc_i  (byte_ok),
    .cnt_o  (cur_cnt_o)
  );

  rxc_last_det #(.W(CNT_W)) u_last (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .byte_i (byte_ok),
    .ext_i  (ctl.ext),
    .cur_i  (cur_cnt_o),
    .prog_i (ctl.cnt),
    .last_o (last_byte_o)
  );
endmodule

// File: rtl/rxc_counter_chk.sv
module rxc_counter_chk
  import i2c_rxc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [REG_W-1:0] cfg_wdata_i,
  input logic [REG_W-1:0] cfg_rdata_o,
  input logic             byte_rx_i,
  input logic [CNT_W-1:0] cur_cnt_o,
  input logic             last_byte_o
);
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[REG_W-1:CNT_W+1] == '0); // R2

  AST_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cur_cnt_o == '0 && !last_byte_o)); // R3

  AST_STROBE_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_rx_i && !cfg_we_i) |=> (cur_cnt_o == $past(cur_cnt_o) + 1'b1)); // R4

  AST_LAST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_byte_o |-> $past(byte_rx_i && !cfg_we_i && !cfg_rdata_o[CNT_W]
                          && cur_cnt_o == cfg_rdata_o[CNT_W-1:0])); // R5

  AST_LAST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_byte_o |=> !last_byte_o); // R5

  AST_EXT_NO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[CNT_W] && !cfg_we_i) |=> !last_byte_o); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_rx_i && !cfg_we_i) |=> ($stable(cur_cnt_o) && !last_byte_o)); // R8
endmodule

bind i2c_rx_byte_counter rxc_counter_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .byte_rx_i   (byte_rx_i),
  .cur_cnt_o   (cur_cnt_o),
  .last_byte_o (last_byte_o)
);

// File: tb/sim_i2c_rx_byte_counter.sv
module sim_i2c_rx_byte_counter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        byte_rx_i = 1'b0;
  logic [7:0]  cur_cnt_o;
  logic        last_byte_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  // model state
  logic [7:0] m_prog = '0;
  logic       m_ext  = 1'b0;
  logic [7:0] m_cur  = '0;
  logic       m_last = 1'b0;
  int unsigned n_last = 0;

  always #4 clk_i = ~clk_i;

  i2c_rx_byte_counter u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .byte_rx_i   (byte_rx_i),
    .cur_cnt_o   (cur_cnt_o),
    .last_byte_o (last_byte_o)
  );

  function automatic logic [15:0] exp_rdata(logic e, logic [7:0] p);
    return {7'b0, e, p};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle at negedge, update model, check after the edge
  task automatic step(logic we, logic [15:0] wd, logic rx, string req);
    cfg_we_i    = we;
    cfg_wdata_i = wd;
    byte_rx_i   = rx;
    m_last = rx && !we && !m_ext && (m_cur == m_prog);
    if (we) begin
      m_prog = wd[7:0];
      m_ext  = wd[8];
      m_cur  = '0;
    end else if (rx) begin
      m_cur = m_cur + 8'd1;
    end
    if (m_last) n_last++;
    @(posedge clk_i);
    #2;
    check({req, " cur"},   {24'b0, cur_cnt_o}, {24'b0, m_cur});
    check({req, " last"},  {31'b0, last_byte_o}, {31'b0, m_last});
    check({req, " rdata"}, {16'b0, cfg_rdata_o}, {16'b0, exp_rdata(m_ext, m_prog)});
    @(negedge clk_i);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned seed;
    int unsigned r;
    seed = 32'd5713;
    r = $urandom(seed);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 cur",   {24'b0, cur_cnt_o},   32'd0);
    check("R1 last",  {31'b0, last_byte_o}, 32'd0);
    check("R1 rdata", {16'b0, cfg_rdata_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 upper bits dropped on readback
    step(1'b1, 16'hFE5A, 1'b0, "R2");
    // R6 count 0 ends on first byte
    step(1'b1, 16'h0000, 1'b0, "R6");
    n_last = 0;
    step(1'b0, '0, 1'b1, "R6");
    check("R6 pulse", {31'b0, last_byte_o}, 32'd1);
    step(1'b0, '0, 1'b0, "R8");
    check("R5 single", {31'b0, last_byte_o}, 32'd0);

    // R3 write and strobe in the same cycle
    step(1'b1, 16'h0003, 1'b0, "R3");
    step(1'b0, '0, 1'b1, "R4");
    step(1'b1, 16'h0003, 1'b1, "R3");
    check("R3 clr", {24'b0, cur_cnt_o}, 32'd0);

    // R7 extended 256 bytes, then R5 reload for 156 more (412 total)
    step(1'b1, 16'h0100, 1'b0, "R7");
    n_last = 0;
    for (int i = 0; i < 256; i++) step(1'b0, '0, 1'b1, "R7");
    check("R7 wrap", {24'b0, cur_cnt_o}, 32'd0);
    check("R7 nolast", n_last, 32'd0);
    step(1'b1, 16'h009B, 1'b0, "R5");
    for (int i = 0; i < 155; i++) step(1'b0, '0, 1'b1, "R5");
    check("R5 early", {31'b0, last_byte_o}, 32'd0);
    step(1'b0, '0, 1'b1, "R5");
    check("R5 at 156", {31'b0, last_byte_o}, 32'd1);
    check("R5 count", n_last, 32'd1);

    // R4 wrap without extend keeps counting modulo 256
    step(1'b1, 16'h0005, 1'b0, "R4");
    for (int i = 0; i < 260; i++) step(1'b0, '0, 1'b1, "R4");

    // random mix: R3 R4 R5 R7 R8
    for (int i = 0; i < 4000; i++) begin
      logic        we;
      logic [15:0] wd;
      we = ($urandom % 24) == 0;
      wd = 16'($urandom);
      if (($urandom % 3) == 0) wd[7:0] = 8'($urandom % 4);
      step(we, wd, 1'(($urandom % 3) != 0), "R4/R5 random");
    end

    // R1 reset mid-run
    rst_ni = 1'b0;
    #1;
    check("R1 async cur",   {24'b0, cur_cnt_o},   32'd0);
    check("R1 async rdata", {16'b0, cfg_rdata_o}, 32'd0);
    summary();
  end
endmodule